// File: doc/BRIEF.md
# Instruction Word Decoder with Immediate Prefix Merging

This block turns one 16-bit instruction word into the fields an execution stage needs: a 5-bit canonical opcode, the destination and source register indices, a 16-bit immediate (sign-extended, zero-extended or scaled as the form requires) and a flag that says whether an immediate is present. The two low bits of the word select one of four layouts. Some layouts use bits that would otherwise hold the opcode to carry a larger immediate. For those layouts the decoder rebuilds the opcode from the layout code and the few opcode bits that remain. The immediate form of an instruction therefore decodes to the same opcode as its register form.

A prefix word can widen the immediate of the next instruction. The prefix supplies twelve upper bits and sets a pending state. The next accepted instruction that carries an immediate receives those twelve bits on top of the low four bits of its own immediate field. Any accepted instruction that is not itself a prefix clears the pending state. Encodings that are reserved or that the decoder does not recognise come out as a no-operation and raise an illegal flag.

The decode path is purely combinational from `instr`. The only state is the pending prefix, which changes on a clock edge when `instr_valid` is high.

Top module: `rjd_decoder`

## Requirements
- R1: After reset no prefix is pending (`imm_pending` = 0), so the first immediate decoded after reset is its plain extended value.
- R2: Layout 00 (`instr[1:0]`=00) is the register form. When bit 7 is 0, opcode = `instr[6:2]`, rd = `instr[15:12]`, rs = `instr[11:8]`, `has_imm` = 0 and imm = 0. A register-form opcode of 11 is reported as 9.
- R3: Register-form opcodes 0 to 3 (no-op, mode return, error stop, normal stop) report rd = 0 and rs = 0, whatever bits [15:8] hold.
- R4: Layout 11 is the short-immediate form. Opcode = 16 + `instr[5:2]`, rd = `instr[15:12]`, rs = 0, and imm = the 6-bit signed field `instr[11:6]` sign-extended to 16 bits.
- R5: Low nibble 0001 is the byte-move form. Opcode = 6, rd = `instr[15:12]`, and imm = signed `instr[11:4]` sign-extended.
- R6: Low five bits x0101 are the relative-branch form, with bit 4 = 0 for jump (opcode 8) and bit 4 = 1 for call (opcode 10). Imm = signed `instr[15:5]` sign-extended. rd = rs = 0.
- R7: Layout 10 is the memory-offset form. Opcode = 12 + `instr[3:2]`, rd = `instr[15:12]`, rs = `instr[11:8]`, and the 4-bit offset `instr[7:4]` is zero-extended. The offset is doubled for the word opcodes 12 and 13 and left unscaled for the byte opcodes 14 and 15.
- R8: Low nibble 1101 is the prefix form. Opcode = 9, `has_imm` = 1, and imm = {`instr[15:4]`, 4'b0000}. An accepted prefix sets `imm_pending` on the next edge. A register-form opcode 9 or 11 sets no prefix.
- R9: While a prefix is pending, a non-prefix instruction that carries an immediate reports imm = {prefix bits, low 4 bits of its own raw immediate field}. This value is neither extended nor scaled.
- R10: An accepted non-prefix instruction clears `imm_pending`, whether it carries an immediate or not. A second prefix replaces the first. A cycle with `instr_valid` = 0 leaves the pending state unchanged.
- R11: Bit 7 set in layout 00, register-form opcode 7, and low nibble 1001 are illegal. They decode to opcode 0 with rd, rs, imm and `has_imm` all 0 and `illegal` = 1, and an accepted illegal word still clears a pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Word on `instr` is accepted at this edge |
| instr | input | 16 | Instruction word |
| opcode | output | 5 | Canonical opcode |
| rd | output | 4 | Destination register index |
| rs | output | 4 | Source register index |
| imm | output | 16 | Final immediate value |
| has_imm | output | 1 | Word carries an immediate |
| illegal | output | 1 | Word is reserved or unrecognised |
| imm_pending | output | 1 | A prefix is waiting for the next instruction |

## Verification
The bench targets the boundaries of sign extension (largest positive and most negative short, byte and branch immediates). A decoder that zero-extends these, or that takes the field one bit off, returns values that differ in the upper bits. It checks that an immediate form and its register form give the same opcode, and that jump and call are told apart by bit 4; an opcode rebuilt from the wrong bits would show up as a neighbouring opcode. The prefix lifetime gets its own tests: a prefix followed by a register-form instruction, an idle cycle, a second prefix, and an illegal word. A tracker that ignores `instr_valid`, never clears, or keeps the first prefix would merge stale bits into a later immediate. Word offsets are checked both doubled and, under a prefix, unscaled, so scaling applied at the wrong point would show.

// File: rtl/rjd_pkg.sv
// Shared constants and opcode names for the instruction decoder.
// Assumes a fixed 16-bit instruction word with a 4-bit immediate remainder.
package rjd_pkg;
    localparam int INSTR_W = 16;
    localparam int OP_W    = 5;
    localparam int REG_W   = 4;
    localparam int IMM_W   = 16;
    localparam int LO_W    = 4;
    localparam int PFX_W   = IMM_W - LO_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 5'd0,
        OP_MOVE   = 5'd6,
        OP_LOADC  = 5'd7,
        OP_JUMP   = 5'd8,
        OP_PREFIX = 5'd9,
        OP_CALL   = 5'd10,
        OP_PFXALT = 5'd11
    } op_name_e;

    typedef enum logic [1:0] {
        LAY_REG  = 2'b00,
        LAY_WIDE = 2'b01,
        LAY_MEM  = 2'b10,
        LAY_SIMM = 2'b11
    } layout_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs;
        logic [IMM_W-1:0] imm;
        logic [LO_W-1:0]  imm_lo;
        logic             has_imm;
        logic             is_prefix;
        logic [PFX_W-1:0] pfx_bits;
        logic             illegal;
    } field_t;
endpackage

// File: rtl/rjd_field_decode.sv
// Field decoder: splits one instruction word into opcode, register indices
// and an extended immediate, rebuilding the opcode for immediate layouts.
// Assumes rjd_pkg widths; purely combinational.
module rjd_field_decode
    import rjd_pkg::*;
#(
    parameter int W = INSTR_W
) (
    input  logic [W-1:0] word,
    output field_t       fld
);
    localparam int SIMM_W = 6;
    localparam int BIMM_W = 8;
    localparam int JIMM_W = 11;
    localparam int OFS_W  = 4;

    logic [1:0] lay;
    assign lay = word[1:0];

    // Decode fields by layout; unknown encodings fall to an illegal no-op.
    always_comb begin
        fld = '0;
        fld.op = OP_NOP;
        unique case (lay)
            LAY_REG: begin
                if (word[7] || (word[6:2] == OP_LOADC)) begin
                    fld.illegal = 1'b1;
                end else begin
                    fld.op = (word[6:2] == OP_PFXALT) ? OP_PREFIX : word[6:2];
                    if (word[6:2] > 5'd3) begin
                        fld.rd = word[15:12];
                        fld.rs = word[11:8];
                    end
                end
            end
            LAY_SIMM: begin
                fld.op      = {1'b1, word[5:2]};
                fld.rd      = word[15:12];
                fld.has_imm = 1'b1;
                fld.imm     = {{(IMM_W-SIMM_W){word[11]}}, word[11:6]};
                fld.imm_lo  = word[9:6];
            end
            LAY_MEM: begin
                fld.op      = {3'b011, word[3:2]};
                fld.rd      = word[15:12];
                fld.rs      = word[11:8];
                fld.has_imm = 1'b1;
                fld.imm_lo  = word[7:4];
                if (!word[3])
                    fld.imm = {{(IMM_W-OFS_W-1){1'b0}}, word[7:4], 1'b0};
                else
                    fld.imm = {{(IMM_W-OFS_W){1'b0}}, word[7:4]};
            end
            LAY_WIDE: begin
                unique case (word[3:2])
                    2'b00: begin
                        fld.op      = OP_MOVE;
                        fld.rd      = word[15:12];
                        fld.has_imm = 1'b1;
                        fld.imm     = {{(IMM_W-BIMM_W){word[11]}}, word[11:4]};
                        fld.imm_lo  = word[7:4];
                    end
                    2'b01: begin
                        fld.op      = word[4] ? OP_CALL : OP_JUMP;
                        fld.has_imm = 1'b1;
                        fld.imm     = {{(IMM_W-JIMM_W){word[15]}}, word[15:5]};
                        fld.imm_lo  = word[8:5];
                    end
                    2'b10: begin
                        fld.illegal = 1'b1;
                    end
                    default: begin
                        fld.op        = OP_PREFIX;
                        fld.has_imm   = 1'b1;
                        fld.is_prefix = 1'b1;
                        fld.pfx_bits  = word[15:4];
                        fld.imm       = {word[15:4], {LO_W{1'b0}}};
                    end
                endcase
            end
            default: fld.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/rjd_prefix_track.sv
// Prefix tracker: holds the upper immediate bits supplied by a prefix word
// until the next accepted instruction consumes them.
// Assumes synchronous active-low reset and one accepted word per valid edge.
module rjd_prefix_track
    import rjd_pkg::*;
#(
    parameter int PW = PFX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          is_prefix,
    input  logic [PW-1:0] bits_in,
    output logic          pending,
    output logic [PW-1:0] bits_out
);
    // Arm on an accepted prefix, release on any other accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            bits_out <= '0;
        end else if (take) begin
            pending <= is_prefix;
            if (is_prefix)
                bits_out <= bits_in;
        end
    end

    p_prefix_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_prefix) |=> (pending && bits_out == $past(bits_in)));

    p_prefix_consumed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_prefix) |=> !pending);

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(pending) && $stable(bits_out)));
endmodule

// File: rtl/rjd_imm_merge.sv
// Immediate merge: replaces the upper bits of an immediate with pending
// prefix bits. Assumes the prefix itself never merges into its own value.
module rjd_imm_merge
    import rjd_pkg::*;
#(
    parameter int IW = IMM_W,
    localparam int PW = IW - LO_W
) (
    input  logic          pending,
    input  logic [PW-1:0] pfx_bits,
    input  logic          has_imm,
    input  logic          is_prefix,
    input  logic [IW-1:0] imm_in,
    input  logic [LO_W-1:0] imm_lo,
    output logic [IW-1:0] imm_out
);
    // Choose merged or plain immediate.
    always_comb begin
        if (pending && has_imm && !is_prefix)
            imm_out = {pfx_bits, imm_lo};
        else
            imm_out = imm_in;
    end
endmodule

// File: rtl/rjd_decoder.sv
// Top of the instruction decoder: field decode, prefix tracking and
// immediate merge. Outputs follow instr combinationally; only the pending
// prefix is state. Assumes synchronous active-low reset.
module rjd_decoder
    import rjd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    output logic [OP_W-1:0]     opcode,
    output logic [REG_W-1:0]    rd,
    output logic [REG_W-1:0]    rs,
    output logic [IMM_W-1:0]    imm,
    output logic                has_imm,
    output logic                illegal,
    output logic                imm_pending
);
    field_t           fld;
    logic [PFX_W-1:0] held_bits;

    rjd_field_decode #(.W(INSTR_W)) u_fields (
        .word (instr),
        .fld  (fld)
    );

    rjd_prefix_track #(.PW(PFX_W)) u_prefix (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (instr_valid),
        .is_prefix (fld.is_prefix),
        .bits_in   (fld.pfx_bits),
        .pending   (imm_pending),
        .bits_out  (held_bits)
    );

    rjd_imm_merge #(.IW(IMM_W)) u_merge (
        .pending   (imm_pending),
        .pfx_bits  (held_bits),
        .has_imm   (fld.has_imm),
        .is_prefix (fld.is_prefix),
        .imm_in    (fld.imm),
        .imm_lo    (fld.imm_lo),
        .imm_out   (imm)
    );

    assign opcode  = fld.op;
    assign rd      = fld.rd;
    assign rs      = fld.rs;
    assign has_imm = fld.has_imm;
    assign illegal = fld.illegal;

    p_simm_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[1:0] == 2'b11) |-> (opcode[4] && has_imm && rs == '0));

    p_reg_no_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[1:0] == 2'b00) |-> (!has_imm && imm == '0));

    p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (opcode == '0 && imm == '0 && !has_imm && rd == '0 && rs == '0));

    p_sys_no_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (has_imm == 1'b0 && opcode < 5'd4) |-> (rd == '0 && rs == '0));
endmodule

// File: tb/rjd_decoder_bench.sv
module rjd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [4:0]  opcode;
    logic [3:0]  rd, rs;
    logic [15:0] imm;
    logic        has_imm, illegal, imm_pending;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rjd_decoder u_rjd_decoder (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .opcode(opcode), .rd(rd), .rs(rs), .imm(imm), .has_imm(has_imm),
        .illegal(illegal), .imm_pending(imm_pending)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present a word just after a falling edge; outputs settle before the rise.
    task automatic put(input logic [15:0] w, input logic v);
        @(negedge clk);
        instr = w;
        instr_valid = v;
        #3;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_r1();
        put(16'h123D, 1'b1);
        do_reset();
        put(16'h37F1, 1'b1);
        chk("R1", "pending after reset", {15'd0, imm_pending}, 16'd0);
        chk("R1", "unmerged move imm", imm, 16'h007F);
    endtask

    task automatic t_reg_r2();
        put(16'hD240, 1'b1);
        chk("R2", "add opcode", {11'd0, opcode}, 16'd16);
        chk("R2", "rd", {12'd0, rd}, 16'd13);
        chk("R2", "rs", {12'd0, rs}, 16'd2);
        chk("R2", "has_imm", {15'd0, has_imm}, 16'd0);
        put(16'h5930, 1'b1);
        chk("R2", "reg load opcode", {11'd0, opcode}, 16'd12);
        chk("R2", "reg load imm", imm, 16'd0);
        put(16'h002C, 1'b1);
        chk("R2", "alias 11 opcode", {11'd0, opcode}, 16'd9);
    endtask

    task automatic t_sys_r3();
        put(16'h740C, 1'b1);
        chk("R3", "halt opcode", {11'd0, opcode}, 16'd3);
        chk("R3", "halt rd/rs", {8'd0, rd, rs}, 16'd0);
        put(16'hFF04, 1'b1);
        chk("R3", "rets opcode", {11'd0, opcode}, 16'd1);
        chk("R3", "rets rd/rs", {8'd0, rd, rs}, 16'd0);
    endtask

    task automatic t_simm_r4();
        put(16'h3FD3, 1'b1);
        chk("R4", "xor opcode", {11'd0, opcode}, 16'd20);
        chk("R4", "imm -1", imm, 16'hFFFF);
        chk("R4", "rd", {12'd0, rd}, 16'd3);
        put(16'h17C3, 1'b1);
        chk("R4", "imm +31", imm, 16'h001F);
        chk("R4", "add opcode", {11'd0, opcode}, 16'd16);
        put(16'hF83F, 1'b1);
        chk("R4", "imm -32", imm, 16'hFFE0);
        chk("R4", "opcode 31", {11'd0, opcode}, 16'd31);
    endtask

    task automatic t_move_r5();
        put(16'h3851, 1'b1);
        chk("R5", "move opcode", {11'd0, opcode}, 16'd6);
        chk("R5", "imm -123", imm, 16'hFF85);
        chk("R5", "rd", {12'd0, rd}, 16'd3);
    endtask

    task automatic t_branch_r6();
        put(16'h8005, 1'b1);
        chk("R6", "jump opcode", {11'd0, opcode}, 16'd8);
        chk("R6", "imm -1024", imm, 16'hFC00);
        put(16'h00B5, 1'b1);
        chk("R6", "call opcode", {11'd0, opcode}, 16'd10);
        chk("R6", "call imm", imm, 16'h0005);
    endtask

    task automatic t_mem_r7();
        put(16'h6F92, 1'b1);
        chk("R7", "word load opcode", {11'd0, opcode}, 16'd12);
        chk("R7", "word offset doubled", imm, 16'h0012);
        chk("R7", "rs", {12'd0, rs}, 16'd15);
        put(16'h2CAE, 1'b1);
        chk("R7", "byte store opcode", {11'd0, opcode}, 16'd15);
        chk("R7", "byte offset", imm, 16'h000A);
        chk("R7", "rd/rs", {8'd0, rd, rs}, 16'h002C);
    endtask

    task automatic t_prefix_r8();
        put(16'h123D, 1'b1);
        chk("R8", "prefix opcode", {11'd0, opcode}, 16'd9);
        chk("R8", "prefix imm", imm, 16'h1230);
        put(16'h0024, 1'b1);
        chk("R8", "pending after prefix", {15'd0, imm_pending}, 16'd1);
        chk("R8", "reg-form 9 no imm", {15'd0, has_imm}, 16'd0);
        put(16'h0000, 1'b0);
        chk("R8", "reg-form 9 arms nothing", {15'd0, imm_pending}, 16'd0);
    endtask

    task automatic t_merge_r9();
        put(16'hABCD, 1'b1);
        put(16'h1D43, 1'b1);
        chk("R9", "merged short imm", imm, 16'hABC5);
        put(16'hABCD, 1'b1);
        put(16'h6F92, 1'b1);
        chk("R9", "merged offset unscaled", imm, 16'hABC9);
        put(16'h0FFD, 1'b1);
        put(16'h00B5, 1'b1);
        chk("R9", "merged branch", imm, 16'h0FF5);
    endtask

    task automatic t_clear_r10();
        put(16'h123D, 1'b1);
        put(16'hD240, 1'b1);
        put(16'h37F1, 1'b1);
        chk("R10", "cleared by reg word", imm, 16'h007F);
        put(16'h555D, 1'b1);
        put(16'h0000, 1'b0);
        put(16'h0000, 1'b0);
        chk("R10", "idle keeps pending", {15'd0, imm_pending}, 16'd1);
        put(16'h3071, 1'b1);
        chk("R10", "merge after idle", imm, 16'h5557);
        put(16'h111D, 1'b1);
        put(16'h222D, 1'b1);
        put(16'h3071, 1'b1);
        chk("R10", "second prefix wins", imm, 16'h2227);
        put(16'h0000, 1'b0);
        chk("R10", "consumed", {15'd0, imm_pending}, 16'd0);
    endtask

    task automatic t_illegal_r11();
        put(16'h0080, 1'b1);
        chk("R11", "bit7 illegal", {15'd0, illegal}, 16'd1);
        put(16'h531C, 1'b1);
        chk("R11", "loadc illegal", {15'd0, illegal}, 16'd1);
        chk("R11", "loadc opcode", {11'd0, opcode}, 16'd0);
        chk("R11", "loadc rd/rs", {8'd0, rd, rs}, 16'd0);
        put(16'h777D, 1'b1);
        put(16'h1239, 1'b1);
        chk("R11", "nibble 1001 illegal", {15'd0, illegal}, 16'd1);
        chk("R11", "nibble 1001 imm", {imm[14:0], has_imm}, 16'd0);
        put(16'h0000, 1'b0);
        chk("R11", "illegal consumes prefix", {15'd0, imm_pending}, 16'd0);
        put(16'hD240, 1'b1);
        chk("R11", "legal word not flagged", {15'd0, illegal}, 16'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset_r1();
        t_reg_r2();
        t_sys_r3();
        t_simm_r4();
        t_move_r5();
        t_branch_r6();
        t_mem_r7();
        t_prefix_r8();
        t_merge_r9();
        t_clear_r10();
        t_illegal_r11();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule